// File: doc/BRIEF.md
# Serial PSRAM Memory-Mapped Controller

This block lets an external serial pseudo-static RAM or serial SRAM sit on a simple memory-mapped bus as if it were plain memory. A bus access to the data region becomes one serial transaction. The controller drops chip enable, sends a command byte and a 24-bit address, inserts wait clocks for reads, moves one, two or four data bytes, and raises chip enable again. The bus is stalled for the whole transaction: `bus_ready` pulses only after chip enable is back high.

Software sets up the link through write-only configuration registers. These hold the read, write, enter-quad and exit-quad command bytes, the read wait-state count, and the line mode. The line mode is single-line SPI, quad-SPI (single-line command, four-line address and data) or QPI (four lines throughout). Two trigger registers arm the controller. While either trigger is set, the next data access sends only the chosen mode-switch command byte. This is how the memory is moved into or out of quad operation before the mode register is changed.

The sequencer uses these states: `ST_IDLE`, `ST_SETUP`, `ST_CMD`, `ST_ADDR`, `ST_WAIT`, `ST_WDATA`, `ST_RDATA` and `ST_DONE`.
- `ST_IDLE` goes to `ST_SETUP` on a data access and to `ST_DONE` on a configuration access.
- `ST_SETUP` goes to `ST_CMD`.
- `ST_CMD` goes to `ST_DONE` when a trigger is armed, and to `ST_ADDR` otherwise.
- `ST_ADDR` goes to `ST_WDATA` for a write. For a read it goes to `ST_WAIT` if the wait count is non-zero, and to `ST_RDATA` otherwise.
- `ST_WAIT` goes to `ST_RDATA`.
- `ST_WDATA` and `ST_RDATA` go to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `psram_mmio_ctrl`

## Requirements
- R1: After reset `ce_n`=1, `sck`=0, `douten`=0 and `bus_ready`=0. The read command is 0x03, the write command 0x02, enter-quad 0xFE's partner 0x35, exit-quad 0xFE, wait count 0, mode 0 (single-line SPI), and both triggers are clear.
- R2: An access with `bus_addr[27]`=1 is a configuration access. A write whose address has bits [26:16]=0 and bits [7:0]=0 updates the register selected one-hot by bits [15:8], taking the low bits of `bus_wdata`. The select values are: 0x01 read command, 0x02 write command, 0x04 enter-quad command, 0x08 exit-quad command, 0x10 wait count, 0x20 mode {qpi,qspi}, 0x40 enter trigger (bit 0), 0x80 exit trigger (bit 0). Any other configuration address changes nothing. Every configuration access completes with `bus_ready` and never drops `ce_n`.
- R3: In mode 0 the 8-bit command and the address `bus_addr[23:0]` go out MSB first on `dout[0]`, one bit per `sck` period. Read data returns on `din[1]`.
- R4: Reads insert exactly the programmed number of idle `sck` periods between the address and the data. Writes insert none.
- R5: In mode 1 (quad-SPI) the command takes 8 single-line clocks on `dout[0]`. Address and data move a nibble per clock on `dout[3:0]`/`din[3:0]`, bit 3 most significant, high nibble first.
- R6: In mode 2 (QPI) the command, address and data all move a nibble per clock on the four lines.
- R7: `bus_size` 0, 1 and 2 transfer 1, 2 and 4 bytes at consecutive addresses, lowest address first. The k-th serial byte maps to `bus_rdata[8k+7:8k]`, and unused upper bytes read as 0.
- R8: `douten` is 1 exactly during the command, address and write-data fields. It is 0 during wait clocks and read data.
- R9: While the enter trigger is set, a data access sends only the enter-quad command byte, with no address and no data. The exit trigger does the same with the exit-quad command, and enter wins if both are set. Clearing the trigger restores normal transfers.
- R10: `bus_ready` is a one-cycle pulse issued only while `ce_n`=1. For a data access `ce_n` stays low from the first command clock to the last data clock.
- R11: `sck` idles low, and `dout` changes only while `sck` is low, so the memory samples on the rising edge.
- R12: Write byte k is taken from `bus_wdata[8k+7:8k]` and is sent k-th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 28 | Byte address; bit 27 selects configuration space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access complete |
| sck | output | 1 | Serial clock |
| ce_n | output | 1 | Active-low chip enable |
| din | input | 4 | Serial data from memory |
| dout | output | 4 | Serial data to memory |
| douten | output | 1 | Output enable for `dout` |

## Verification
The hardest situation to reach is the set of armed trigger transactions. These are truncated frames that end straight after the command byte. They must send the right byte at the lane width of the mode that is current before the switch. The bench reaches them only through a sequence of configuration writes: arm the trigger, make a dummy data access, and disarm. For the exit case, QPI is selected first so that the exit command must travel on four lines in two clocks. A memory model in the bench follows the mode that the bench itself programmed, and it counts rising `sck` edges per frame. A frame that is too long, or a command decoded on the wrong lines, shows up as a wrong edge count or a wrong command byte.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W = 24;
    localparam int WAIT_W = 8;
    localparam int CNT_W  = (WAIT_W > 6) ? WAIT_W : 6;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;

    localparam logic [SEL_W-1:0] SEL_RD_CMD = 8'h01;
    localparam logic [SEL_W-1:0] SEL_WR_CMD = 8'h02;
    localparam logic [SEL_W-1:0] SEL_EQ_CMD = 8'h04;
    localparam logic [SEL_W-1:0] SEL_XQ_CMD = 8'h08;
    localparam logic [SEL_W-1:0] SEL_WAIT   = 8'h10;
    localparam logic [SEL_W-1:0] SEL_MODE   = 8'h20;
    localparam logic [SEL_W-1:0] SEL_EQ_ARM = 8'h40;
    localparam logic [SEL_W-1:0] SEL_XQ_ARM = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ADDR,
        ST_WAIT,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } psram_state_e;

    typedef struct packed {
        logic [7:0]        rd_cmd;
        logic [7:0]        wr_cmd;
        logic [7:0]        eq_cmd;
        logic [7:0]        xq_cmd;
        logic [WAIT_W-1:0] wait_cyc;
        logic              qpi;
        logic              qspi;
        logic              eq_arm;
        logic              xq_arm;
    } psram_cfg_t;

endpackage

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
    import psram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output psram_cfg_t        cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.rd_cmd   <= 8'h03;
            cfg.wr_cmd   <= 8'h02;
            cfg.eq_cmd   <= 8'h35;
            cfg.xq_cmd   <= 8'hFE;
            cfg.wait_cyc <= '0;
            cfg.qpi      <= 1'b0;
            cfg.qspi     <= 1'b0;
            cfg.eq_arm   <= 1'b0;
            cfg.xq_arm   <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_RD_CMD: cfg.rd_cmd   <= wdata[7:0];
                SEL_WR_CMD: cfg.wr_cmd   <= wdata[7:0];
                SEL_EQ_CMD: cfg.eq_cmd   <= wdata[7:0];
                SEL_XQ_CMD: cfg.xq_cmd   <= wdata[7:0];
                SEL_WAIT:   cfg.wait_cyc <= wdata[WAIT_W-1:0];
                SEL_MODE: begin
                    cfg.qpi  <= wdata[1];
                    cfg.qspi <= wdata[0];
                end
                SEL_EQ_ARM: cfg.eq_arm   <= wdata[0];
                SEL_XQ_ARM: cfg.xq_arm   <= wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/psram_shifter.sv
module psram_shifter
    import psram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              adv,
    input  logic              cap,
    input  logic              clr_rx,
    input  logic              quad,
    input  logic [3:0]        din,
    output logic [3:0]        dout,
    output logic [DATA_W-1:0] rx
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (ld) begin
            tx_q <= ld_val;
        end else if (adv) begin
            tx_q <= quad ? {tx_q[DATA_W-5:0], 4'b0000} : {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (clr_rx) begin
            rx_q <= '0;
        end else if (cap) begin
            rx_q <= quad ? {rx_q[DATA_W-5:0], din} : {rx_q[DATA_W-2:0], din[1]};
        end
    end

    assign dout = quad ? tx_q[DATA_W-1:DATA_W-4] : {3'b000, tx_q[DATA_W-1]};
    assign rx   = rx_q;

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              cfg_hit,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata_sw,
    input  psram_cfg_t        cfg,
    output logic              cfg_wr,
    output logic              ld,
    output logic [DATA_W-1:0] ld_val,
    output logic              adv,
    output logic              cap,
    output logic              clr_rx,
    output logic              quad,
    output logic [1:0]        size_q,
    output logic              ce_n,
    output logic              sck,
    output logic              douten,
    output logic              ready
);

    psram_state_e      state, nstate;
    logic [CNT_W-1:0]  cnt;
    logic              ph;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic              cmd_quad, dat_quad, special, shifting, beat_end;
    logic [7:0]        cmd_byte;
    logic [CNT_W-1:0]  last_cmd, last_addr, last_data, last_wait, next_last;

    always_comb begin
        cmd_quad  = cfg.qpi;
        dat_quad  = cfg.qpi | cfg.qspi;
        special   = cfg.eq_arm | cfg.xq_arm;
        if (cfg.eq_arm)      cmd_byte = cfg.eq_cmd;
        else if (cfg.xq_arm) cmd_byte = cfg.xq_cmd;
        else if (we_q)       cmd_byte = cfg.wr_cmd;
        else                 cmd_byte = cfg.rd_cmd;
        last_cmd  = cmd_quad ? CNT_W'(1) : CNT_W'(7);
        last_addr = dat_quad ? CNT_W'(ADDR_W/4 - 1) : CNT_W'(ADDR_W - 1);
        unique case (size_q)
            2'd0:    last_data = dat_quad ? CNT_W'(1) : CNT_W'(7);
            2'd1:    last_data = dat_quad ? CNT_W'(3) : CNT_W'(15);
            default: last_data = dat_quad ? CNT_W'(7) : CNT_W'(31);
        endcase
        last_wait = CNT_W'(cfg.wait_cyc) - 1'b1;
        shifting  = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_WAIT) ||
                    (state == ST_WDATA) || (state == ST_RDATA);
        beat_end  = shifting && ph && (cnt == '0);
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (req) nstate = cfg_hit ? ST_DONE : ST_SETUP;
            ST_SETUP: nstate = ST_CMD;
            ST_CMD:   if (beat_end) nstate = special ? ST_DONE : ST_ADDR;
            ST_ADDR: begin
                if (beat_end) begin
                    if (we_q)                     nstate = ST_WDATA;
                    else if (cfg.wait_cyc != '0)  nstate = ST_WAIT;
                    else                          nstate = ST_RDATA;
                end
            end
            ST_WAIT:  if (beat_end) nstate = ST_RDATA;
            ST_WDATA: if (beat_end) nstate = ST_DONE;
            ST_RDATA: if (beat_end) nstate = ST_DONE;
            ST_DONE:  nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nstate)
            ST_CMD:             next_last = last_cmd;
            ST_ADDR:            next_last = last_addr;
            ST_WAIT:            next_last = last_wait;
            ST_WDATA, ST_RDATA: next_last = last_data;
            default:            next_last = '0;
        endcase
    end

    // state register with beat phase and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ph    <= 1'b0;
        end else begin
            state <= nstate;
            if (nstate != state) begin
                ph  <= 1'b0;
                cnt <= next_last;
            end else if (shifting) begin
                ph <= ~ph;
                if (ph) cnt <= cnt - 1'b1;
            end
        end
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= 2'd0;
        end else if (state == ST_IDLE && req && !cfg_hit) begin
            we_q    <= we;
            addr_q  <= addr;
            wdata_q <= wdata_sw;
            size_q  <= size;
        end
    end

    // outputs
    always_comb begin
        ce_n    = (state == ST_IDLE) || (state == ST_DONE);
        sck     = shifting && ph;
        douten  = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_WDATA);
        ready   = (state == ST_DONE);
        cfg_wr  = (state == ST_IDLE) && req && cfg_hit && we;
        clr_rx  = (state == ST_SETUP);
        quad    = (state == ST_CMD) ? cmd_quad : dat_quad;
        adv     = ph && ((state == ST_CMD) || (state == ST_ADDR) || (state == ST_WDATA));
        cap     = ph && (state == ST_RDATA);
        ld      = (nstate != state) &&
                  ((nstate == ST_CMD) || (nstate == ST_ADDR) || (nstate == ST_WDATA));
        unique case (nstate)
            ST_CMD:  ld_val = {cmd_byte, {(DATA_W-8){1'b0}}};
            ST_ADDR: ld_val = {addr_q, {(DATA_W-ADDR_W){1'b0}}};
            default: ld_val = wdata_q;
        endcase
    end

endmodule

// File: rtl/psram_mmio_ctrl.sv
module psram_mmio_ctrl
    import psram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [27:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic        sck,
    output logic        ce_n,
    input  logic [3:0]  din,
    output logic [3:0]  dout,
    output logic        douten
);

    localparam int NBYTES = DATA_W / 8;

    psram_cfg_t        cfg;
    logic              cfg_wr, cfg_sel_ok;
    logic              ld, adv, cap, clr_rx, quad;
    logic [DATA_W-1:0] ld_val, rx, rx_sw, wdata_sw;
    logic [1:0]        size_q;

    assign cfg_sel_ok = (bus_addr[26:16] == '0) && (bus_addr[7:0] == '0);

    // byte order swaps: lowest-address byte travels first on the wire
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign wdata_sw[8*g +: 8] = bus_wdata[8*(NBYTES-1-g) +: 8];
        assign rx_sw[8*g +: 8]    = rx[8*(NBYTES-1-g) +: 8];
    end

    always_comb begin
        unique case (size_q)
            2'd0:    bus_rdata = rx_sw >> (8 * (NBYTES - 1));
            2'd1:    bus_rdata = rx_sw >> (8 * (NBYTES - 2));
            default: bus_rdata = rx_sw;
        endcase
    end

    psram_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr && cfg_sel_ok),
        .sel   (bus_addr[15:8]),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    psram_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_sel),
        .we       (bus_we),
        .cfg_hit  (bus_addr[27]),
        .size     (bus_size),
        .addr     (bus_addr[ADDR_W-1:0]),
        .wdata_sw (wdata_sw),
        .cfg      (cfg),
        .cfg_wr   (cfg_wr),
        .ld       (ld),
        .ld_val   (ld_val),
        .adv      (adv),
        .cap      (cap),
        .clr_rx   (clr_rx),
        .quad     (quad),
        .size_q   (size_q),
        .ce_n     (ce_n),
        .sck      (sck),
        .douten   (douten),
        .ready    (bus_ready)
    );

    psram_shifter u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_val (ld_val),
        .adv    (adv),
        .cap    (cap),
        .clr_rx (clr_rx),
        .quad   (quad),
        .din    (din),
        .dout   (dout),
        .rx     (rx)
    );

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       sck,
    input logic       douten,
    input logic       bus_ready,
    input logic [3:0] dout
);

    // R10
    ready_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> ce_n);

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !douten);

    // R11
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !sck);

    // R11
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !ce_n) |-> $stable(dout));

    // R10
    ce_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> (!sck && !bus_ready));

endmodule

bind psram_mmio_ctrl psram_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .sck       (sck),
    .douten    (douten),
    .bus_ready (bus_ready),
    .dout      (dout)
);

// File: tb/tb_psram_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_psram_mmio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [27:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        sck, ce_n, douten;
    logic [3:0]  din = 4'h0;
    logic [3:0]  dout;

    psram_mmio_ctrl dut (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int ready_ce_bad = 0;

    // bench knowledge of programmed settings
    logic [1:0] tb_mode = 2'd0;
    int         tb_wait = 0;
    logic [7:0] tb_rd = 8'h03;
    logic [7:0] tb_wr = 8'h02;

    // memory model
    logic [7:0]  mem [0:255];
    int          m_edges = 0, m_wcnt = 0, m_oe_err = 0, m_trans = 0;
    int          m_cl, m_dl, m_ce, m_ae, m_k;
    logic [7:0]  m_cmd = 8'h00, m_byte = 8'h00, m_b;
    logic [23:0] m_addr = '0;
    logic [7:0]  l_cmd;
    logic [23:0] l_addr;
    int          l_edges, l_oe;

    always @(negedge ce_n) begin
        m_edges = 0; m_wcnt = 0; m_oe_err = 0; m_cmd = 8'h00; m_addr = '0;
        m_trans++;
    end

    always @(posedge ce_n) begin
        l_cmd = m_cmd; l_addr = m_addr; l_edges = m_edges; l_oe = m_oe_err;
    end

    always @(posedge sck) if (!ce_n) begin
        m_cl = tb_mode[1] ? 4 : 1;
        m_dl = (tb_mode != 2'd0) ? 4 : 1;
        m_ce = 8 / m_cl;
        m_ae = 24 / m_dl;
        if (m_edges < m_ce) begin
            m_cmd = (m_cl == 4) ? {m_cmd[3:0], dout} : {m_cmd[6:0], dout[0]};
            if (!douten) m_oe_err++;
        end else if (m_cmd == tb_rd || m_cmd == tb_wr) begin
            if (m_edges < m_ce + m_ae) begin
                m_addr = (m_dl == 4) ? {m_addr[19:0], dout} : {m_addr[22:0], dout[0]};
                if (!douten) m_oe_err++;
            end else if (m_cmd == tb_wr) begin
                m_byte = (m_dl == 4) ? {m_byte[3:0], dout} : {m_byte[6:0], dout[0]};
                m_wcnt += m_dl;
                if (m_wcnt % 8 == 0) mem[(int'(m_addr) + m_wcnt/8 - 1) & 255] = m_byte;
                if (!douten) m_oe_err++;
            end else if (douten) begin
                m_oe_err++;
            end
        end
        m_edges++;
    end

    always @(negedge sck) if (!ce_n && m_cmd == tb_rd && m_edges >= m_ce + m_ae + tb_wait) begin
        m_k = m_edges - (m_ce + m_ae + tb_wait);
        if (m_dl == 4) begin
            m_b = mem[(int'(m_addr) + m_k/2) & 255];
            din = (m_k % 2 == 0) ? m_b[7:4] : m_b[3:0];
        end else begin
            m_b = mem[(int'(m_addr) + m_k/8) & 255];
            din = {2'b00, m_b[7 - (m_k % 8)], 1'b0};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic [27:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        do @(negedge clk); while (!bus_ready);
        rd = bus_rdata;
        if (!ce_n) ready_ce_bad++;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] sel, input logic [31:0] val);
        logic [31:0] dummy;
        bus_op(28'h800_0000 | (28'(sel) << 8), 1'b1, 2'd2, val, dummy);
    endtask

    function automatic int frame_edges(input logic [1:0] md, input int wt, input logic [1:0] sz);
        int cl = md[1] ? 4 : 1;
        int dl = (md != 2'd0) ? 4 : 1;
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        return 8/cl + 24/dl + wt + 8*nb/dl;
    endfunction

    // {mode[1:0], wait[7:0], size[1:0], addr[15:0], data[31:0]}
    localparam logic [59:0] VECS [0:7] = '{
        {2'd0, 8'd0, 2'd2, 16'h0010, 32'hA1B2C3D4},
        {2'd0, 8'd3, 2'd0, 16'h0021, 32'h0000005A},
        {2'd1, 8'd0, 2'd1, 16'h0032, 32'h0000BEEF},
        {2'd1, 8'd4, 2'd2, 16'h0040, 32'h13579BDF},
        {2'd2, 8'd0, 2'd2, 16'h0050, 32'h2468ACE0},
        {2'd2, 8'd6, 2'd0, 16'h0063, 32'h0000007E},
        {2'd2, 8'd2, 2'd1, 16'h0070, 32'h00008001},
        {2'd0, 8'd1, 2'd1, 16'h0085, 32'h00000FF0}
    };

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int tr0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state, R11 sck idle low
        chk("R1 ce_n in reset", 32'(ce_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ce_n", 32'(ce_n), 32'd1);
        chk("R11 sck idle low", 32'(sck), 32'd0);
        chk("R1 douten", 32'(douten), 32'd0);
        chk("R1 ready", 32'(bus_ready), 32'd0);

        // R1 default commands, R3 SPI framing
        bus_op(28'h000_0005, 1'b1, 2'd0, 32'h0000003C, rd);
        chk("R1 default write cmd", 32'(l_cmd), 32'h02);
        chk("R3 address", 32'(l_addr), 32'h000005);
        bus_op(28'h000_0005, 1'b0, 2'd0, 32'h0, rd);
        chk("R1 default read cmd", 32'(l_cmd), 32'h03);
        chk("R3 read data", rd, 32'h3C);

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  md = VECS[v][59:58];
            logic [7:0]  wt = VECS[v][57:50];
            logic [1:0]  sz = VECS[v][49:48];
            logic [15:0] ad = VECS[v][47:32];
            logic [31:0] dt = VECS[v][31:0];
            int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            logic [31:0] exp_rd = (sz == 2'd0) ? (dt & 32'hFF) : (sz == 2'd1) ? (dt & 32'hFFFF) : dt;
            cfg_wr(8'h20, 32'(md));
            cfg_wr(8'h10, 32'(wt));
            tb_mode = md; tb_wait = int'(wt);
            bus_op(28'(ad), 1'b1, sz, dt, rd);
            for (int k = 0; k < nb; k++)
                chk("R12 write byte order", 32'(mem[(int'(ad) + k) & 255]), 32'(dt[8*k +: 8]));
            // R4 writes ignore wait count
            chk("R4 write frame length", 32'(l_edges), 32'(frame_edges(md, 0, sz)));
            chk("R8 douten write", 32'(l_oe), 32'd0);
            bus_op(28'(ad), 1'b0, sz, 32'h0, rd);
            chk("R7 read assembly", rd, exp_rd);
            if (md == 2'd0)      chk("R3 read frame length", 32'(l_edges), 32'(frame_edges(md, int'(wt), sz)));
            else if (md == 2'd1) chk("R5 read frame length", 32'(l_edges), 32'(frame_edges(md, int'(wt), sz)));
            else                 chk("R6 read frame length", 32'(l_edges), 32'(frame_edges(md, int'(wt), sz)));
            chk("R4 R8 douten read", 32'(l_oe), 32'd0);
        end

        // R2 reprogram commands
        cfg_wr(8'h20, 32'd0); tb_mode = 2'd0;
        cfg_wr(8'h10, 32'd0); tb_wait = 0;
        cfg_wr(8'h01, 32'h0B); cfg_wr(8'h02, 32'h12);
        tb_rd = 8'h0B; tb_wr = 8'h12;
        bus_op(28'h000_0090, 1'b1, 2'd1, 32'h0000CAFE, rd);
        chk("R2 write cmd reprogrammed", 32'(l_cmd), 32'h12);
        bus_op(28'h000_0090, 1'b0, 2'd1, 32'h0, rd);
        chk("R2 read cmd reprogrammed", 32'(l_cmd), 32'h0B);
        chk("R2 read data", rd, 32'hCAFE);

        // R2 config access leaves serial side idle; bad offset changes nothing
        tr0 = m_trans;
        cfg_wr(8'h03, 32'h55);
        chk("R2 no frame on config write", 32'(m_trans - tr0), 32'd0);
        bus_op(28'h000_0090, 1'b0, 2'd1, 32'h0, rd);
        chk("R2 bad offset ignored", 32'(l_cmd), 32'h0B);

        // R9 enter trigger in SPI
        cfg_wr(8'h40, 32'd1);
        tr0 = m_trans;
        bus_op(28'h000_0010, 1'b0, 2'd2, 32'h0, rd);
        chk("R9 enter cmd", 32'(l_cmd), 32'h35);
        chk("R9 enter frame length", 32'(l_edges), 32'd8);
        chk("R9 one frame", 32'(m_trans - tr0), 32'd1);
        cfg_wr(8'h40, 32'd0);
        bus_op(28'h000_0010, 1'b0, 2'd2, 32'h0, rd);
        chk("R9 normal after disarm", rd, 32'hA1B2C3D4);

        // R9 exit trigger in QPI
        cfg_wr(8'h20, 32'd2); tb_mode = 2'd2;
        cfg_wr(8'h80, 32'd1);
        bus_op(28'h000_0020, 1'b1, 2'd0, 32'h000000EE, rd);
        chk("R9 exit cmd", 32'(l_cmd), 32'hFE);
        chk("R9 exit frame length", 32'(l_edges), 32'd2);
        chk("R9 no data written", 32'(mem[8'h20]), 32'h00);
        cfg_wr(8'h80, 32'd0);
        bus_op(28'h000_0020, 1'b0, 2'd0, 32'h0, rd);
        chk("R6 read after exit disarm", 32'(l_cmd), 32'h0B);

        // R4 write with nonzero wait in SPI
        cfg_wr(8'h20, 32'd0); tb_mode = 2'd0;
        cfg_wr(8'h10, 32'd5); tb_wait = 5;
        bus_op(28'h000_00A0, 1'b1, 2'd0, 32'h00000011, rd);
        chk("R4 write ignores wait", 32'(l_edges), 32'd40);
        bus_op(28'h000_00A0, 1'b0, 2'd0, 32'h0, rd);
        chk("R4 read with wait", 32'(l_edges), 32'd45);
        chk("R4 read data with wait", rd, 32'h11);

        chk("R10 ready only with ce_n high", 32'(ready_ce_bad), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule